// File: doc/BRIEF.md
# Bus Wait-State Generator

This block stretches CPU memory cycles that target slow memory. It looks at the page of each access (the top four address bits) on the cycle the access strobe is sampled. If that page is fast, the access runs with no wait states. Otherwise it pulls the CPU ready line low for exactly two clock cycles. The timing comes from a three-stage shift register whose last stage feeds back inverted into its first stage. The register starts when an access is accepted and runs until it has cleared back to all zeros.

Two page ranges are always fast: 0x0000–0x0FFF and 0x8000–0x9FFF. Three further ranges are fast only while their static enable input is high, so each memory block can be moved onto the zero-wait path on its own. These ranges are cartridge RAM at 0x6000–0x7FFF, low expansion RAM at 0x2000–0x3FFF and high expansion RAM at 0xA000–0xFFFF. All page maps and the number of sequencer stages are parameters.

If a slow access is strobed before the sequencer has cleared, it is queued. The ready line stays low until the queued access has had its own two wait cycles. Every slow access therefore gets a full wait.

Top module: `bus_wait_gen`

## Requirements
- R1: A synchronous active-high reset clears the sequencer and any queued access, and `cpu_ready` is 1 after every edge at which reset is high, including a reset in the middle of a wait.
- R2: A strobe to a slow page while the sequencer is idle drives `cpu_ready` to 0 after that edge and after the next edge. `cpu_ready` is 1 again after the third edge.
- R3: A strobe to any address in 0x0000–0x0FFF leaves `cpu_ready` at 1.
- R4: A strobe to any address in 0x8000–0x9FFF leaves `cpu_ready` at 1.
- R5: 0x6000–0x7FFF is zero-wait when `fast_cart_en` is 1. It gets the two-cycle wait of R2 when `fast_cart_en` is 0.
- R6: 0x2000–0x3FFF is zero-wait when `fast_lo_en` is 1. It gets the R2 wait when `fast_lo_en` is 0.
- R7: 0xA000–0xFFFF is zero-wait when `fast_hi_en` is 1. It gets the R2 wait when `fast_hi_en` is 0. Each enable affects only its own range.
- R8: The fast/slow decision is taken only on the strobe cycle. Changes to the address during the wait, or without a strobe, neither shorten nor start a wait.
- R9: With no strobe and nothing queued, `cpu_ready` stays 1 once the sequencer has cleared.
- R10: After a start, the sequencer is busy for five edges. A slow strobe taken while it is busy is queued and drives `cpu_ready` to 0 after that edge. The queued access starts on the first edge at which the sequencer is clear. `cpu_ready` stays 0 until two edges after that start.
- R11: A fast-page strobe taken while the sequencer is busy is not queued, and the ready pattern of the running access is unchanged.
- R12: A slow strobe that arrives six or more edges after the previous start finds the sequencer idle and gets exactly the R2 pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_strobe | input | 1 | Memory access strobe, sampled at the rising edge |
| acc_addr | input | ADDR_W (16) | CPU address; bits 15..12 select the page |
| fast_cart_en | input | 1 | Makes 0x6000–0x7FFF zero-wait |
| fast_lo_en | input | 1 | Makes 0x2000–0x3FFF zero-wait |
| fast_hi_en | input | 1 | Makes 0xA000–0xFFFF zero-wait |
| cpu_ready | output | 1 | Registered ready line to the CPU; 0 stretches the cycle |

## Verification
The bench targets the range edges, such as 0x0FFF against 0x1000 and 0x9FFE against 0xA000. A decoder with an off-by-one page mask would wait, or fail to wait, at those addresses. It toggles each range enable alone, which exposes an enable wired to the wrong range. It also moves the address to a fast page during a wait; a design that decodes continuously would cut that wait short. Strobes are issued at edge offsets 1, 3, 5 and 6 after a start. A sequencer that restarts from a non-clear state, or drops strobes that arrive while busy, would give a wait that is too short or missing.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int PAGE_BITS = 4;
  localparam int PAGES     = 1 << PAGE_BITS;

  typedef logic [PAGES-1:0] page_map_t;

  // Default page maps, one bit per 4 KiB page
  localparam page_map_t MAP_ALWAYS_FAST = 16'h0301; // pages 0, 8, 9
  localparam page_map_t MAP_CART        = 16'h00C0; // pages 6, 7
  localparam page_map_t MAP_LO_RAM      = 16'h000C; // pages 2, 3
  localparam page_map_t MAP_HI_RAM      = 16'hFC00; // pages A..F
endpackage

// File: rtl/wsg_region_decode.sv
module wsg_region_decode
  import wsg_pkg::*;
#(
  parameter int                    ADDR_W    = 16,
  parameter int                    N_OPT     = 3,
  parameter page_map_t             FIXED_MAP = MAP_ALWAYS_FAST,
  parameter page_map_t [N_OPT-1:0] OPT_MAP   = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_OPT-1:0]  opt_en,
  output logic              fast
);
  logic [PAGE_BITS-1:0] page;
  logic [N_OPT-1:0]     opt_hit;
  logic [ADDR_W-PAGE_BITS-1:0] unused_low;

  assign page       = addr[ADDR_W-1 -: PAGE_BITS];
  assign unused_low = addr[ADDR_W-PAGE_BITS-1:0];

  for (genvar g = 0; g < N_OPT; g++) begin : g_opt
    assign opt_hit[g] = opt_en[g] & OPT_MAP[g][page];
  end

  assign fast = FIXED_MAP[page] | (|opt_hit) | (1'b0 & (|unused_low));
endmodule

// File: rtl/wsg_twisted_ring.sv
module wsg_twisted_ring #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [STAGES-1:0] ring_q,
  output logic [STAGES-1:0] ring_next
);
  // bit 0 is the first stage, bit STAGES-1 the last; last feeds back inverted
  always_comb begin
    if (advance) ring_next = {ring_q[STAGES-2:0], ~ring_q[STAGES-1]};
    else         ring_next = ring_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ring_q <= '0;
    else     ring_q <= ring_next;
  end
endmodule

// File: rtl/wsg_ready_ctrl.sv
module wsg_ready_ctrl #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_strobe,
  input  logic [STAGES-1:0] ring_q,
  input  logic [STAGES-1:0] ring_next,
  output logic              advance,
  output logic              pend_q,
  output logic              cpu_ready
);
  logic idle, start, pend_d, hold_d;

  assign idle    = (ring_q == '0);
  assign start   = idle & (slow_strobe | pend_q);
  assign advance = ~idle | start;

  always_comb begin
    pend_d = pend_q;
    if (start)                    pend_d = 1'b0;
    else if (!idle && slow_strobe) pend_d = 1'b1;
  end

  // wait window: first stage set, last stage still clear
  assign hold_d = (ring_next[0] & ~ring_next[STAGES-1]) | pend_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      cpu_ready <= 1'b1;
    end else begin
      pend_q    <= pend_d;
      cpu_ready <= ~hold_d;
    end
  end
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import wsg_pkg::*;
#(
  parameter int        ADDR_W    = 16,
  parameter int        STAGES    = 3,
  parameter page_map_t FIXED_MAP = MAP_ALWAYS_FAST,
  parameter page_map_t CART_MAP  = MAP_CART,
  parameter page_map_t LO_MAP    = MAP_LO_RAM,
  parameter page_map_t HI_MAP    = MAP_HI_RAM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_strobe,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              fast_cart_en,
  input  logic              fast_lo_en,
  input  logic              fast_hi_en,
  output logic              cpu_ready
);
  localparam int N_OPT = 3;
  localparam page_map_t [N_OPT-1:0] OPT_MAPS = {HI_MAP, LO_MAP, CART_MAP};

  logic              fast;
  logic              slow_strobe;
  logic              advance;
  logic              pend_q;
  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_next;

  wsg_region_decode #(
    .ADDR_W(ADDR_W), .N_OPT(N_OPT), .FIXED_MAP(FIXED_MAP), .OPT_MAP(OPT_MAPS)
  ) u_dec (
    .addr  (acc_addr),
    .opt_en({fast_hi_en, fast_lo_en, fast_cart_en}),
    .fast  (fast)
  );

  assign slow_strobe = acc_strobe & ~fast;

  wsg_twisted_ring #(.STAGES(STAGES)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .ring_q   (ring_q),
    .ring_next(ring_next)
  );

  wsg_ready_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .slow_strobe(slow_strobe),
    .ring_q     (ring_q),
    .ring_next  (ring_next),
    .advance    (advance),
    .pend_q     (pend_q),
    .cpu_ready  (cpu_ready)
  );
endmodule

// File: rtl/bus_wait_gen_chk.sv
module bus_wait_gen_chk #(
  parameter int STAGES = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_strobe,
  input logic [3:0]        acc_page,
  input logic              fast_cart_en,
  input logic              fast_lo_en,
  input logic              fast_hi_en,
  input logic              cpu_ready,
  input logic [STAGES-1:0] ring_q,
  input logic              pend_q
);
  logic quiet;
  assign quiet = (ring_q == '0) && !pend_q;

  // R1
  a_r1_reset_ready: assert property (@(posedge clk) rst |=> cpu_ready);

  // R2
  a_r2_slow_two_waits: assert property (@(posedge clk) disable iff (rst)
    (acc_strobe && quiet && (acc_page == 4'h1 || acc_page == 4'h4 || acc_page == 4'h5))
    |=> !cpu_ready ##1 !cpu_ready);

  // R3, R4
  a_r3_r4_fixed_fast: assert property (@(posedge clk) disable iff (rst)
    (acc_strobe && quiet && (acc_page == 4'h0 || acc_page == 4'h8 || acc_page == 4'h9))
    |=> cpu_ready);

  // R5, R6, R7
  a_r5_r7_enabled_fast: assert property (@(posedge clk) disable iff (rst)
    (acc_strobe && quiet &&
     ((fast_cart_en && (acc_page == 4'h6 || acc_page == 4'h7)) ||
      (fast_lo_en   && (acc_page == 4'h2 || acc_page == 4'h3)) ||
      (fast_hi_en   && acc_page >= 4'hA)))
    |=> cpu_ready);

  // R9
  a_r9_idle_ready: assert property (@(posedge clk) disable iff (rst)
    (quiet && !acc_strobe) |=> cpu_ready);

  // R10
  a_r10_queued_holds_low: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !cpu_ready);

  // R10: ring only ever holds twisted-ring codes
  a_r10_ring_legal: assert property (@(posedge clk) disable iff (rst)
    $countones(ring_q[STAGES-1:1] ^ ring_q[STAGES-2:0]) <= 1);
endmodule

bind bus_wait_gen bus_wait_gen_chk #(.STAGES(STAGES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_strobe  (acc_strobe),
  .acc_page    (acc_addr[ADDR_W-1 -: 4]),
  .fast_cart_en(fast_cart_en),
  .fast_lo_en  (fast_lo_en),
  .fast_hi_en  (fast_hi_en),
  .cpu_ready   (cpu_ready),
  .ring_q      (ring_q),
  .pend_q      (pend_q)
);

// File: tb/bus_wait_gen_tb.sv
module bus_wait_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_strobe = 1'b0;
  logic [15:0] acc_addr = 16'h0000;
  logic        fast_cart_en = 1'b0;
  logic        fast_lo_en = 1'b0;
  logic        fast_hi_en = 1'b0;
  logic        cpu_ready;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_wait_gen u_dut (
    .clk(clk), .rst(rst), .acc_strobe(acc_strobe), .acc_addr(acc_addr),
    .fast_cart_en(fast_cart_en), .fast_lo_en(fast_lo_en), .fast_hi_en(fast_hi_en),
    .cpu_ready(cpu_ready)
  );

  task automatic check16(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: ready pattern actual=%h expected=%h", req, got, exp);
    end
  endtask

  // bit i of mask strobes on edge i; address a0 on edge 0, a1 afterwards.
  // bit i of the result is cpu_ready after edge i.
  task automatic run_pattern(input string req, input logic [15:0] mask,
                             input logic [15:0] a0, input logic [15:0] a1,
                             input logic [15:0] exp);
    logic [15:0] got;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      acc_strobe = mask[i];
      acc_addr   = (i == 0) ? a0 : a1;
      @(negedge clk);
      got[i] = cpu_ready;
    end
    acc_strobe = 1'b0;
    check16(req, got, exp);
  endtask

  task automatic set_en(input logic c, input logic l, input logic h);
    fast_cart_en = c; fast_lo_en = l; fast_hi_en = h;
  endtask

  task automatic t_reset;
    logic [15:0] got;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    got = {15'h7FFF, cpu_ready};
    rst = 1'b0;
    check16("R1 reset state", got, 16'hFFFF);
  endtask

  task automatic t_reset_mid_wait;
    logic [15:0] got;
    @(negedge clk);
    acc_strobe = 1'b1; acc_addr = 16'h4000;
    @(negedge clk);
    acc_strobe = 1'b0;
    got[0] = cpu_ready;
    rst = 1'b1;
    @(negedge clk);
    got[1] = cpu_ready;
    rst = 1'b0;
    for (int i = 2; i < 16; i++) begin
      @(negedge clk);
      got[i] = cpu_ready;
    end
    check16("R1 reset during wait", got, 16'hFFFE);
  endtask

  task automatic t_slow_basic;
    set_en(0, 0, 0);
    run_pattern("R2 slow page 0x4000", 16'h0001, 16'h4000, 16'h4000, 16'hFFFC);
    run_pattern("R2 slow page 0x1000", 16'h0001, 16'h1000, 16'h1000, 16'hFFFC);
  endtask

  task automatic t_fixed_fast;
    set_en(0, 0, 0);
    run_pattern("R3 addr 0x0000", 16'h0001, 16'h0000, 16'h0000, 16'hFFFF);
    run_pattern("R3 addr 0x0FFF", 16'h0001, 16'h0FFF, 16'h0FFF, 16'hFFFF);
    run_pattern("R4 addr 0x8000", 16'h0001, 16'h8000, 16'h8000, 16'hFFFF);
    run_pattern("R4 addr 0x9FFE", 16'h0001, 16'h9FFE, 16'h9FFE, 16'hFFFF);
  endtask

  task automatic t_optional;
    set_en(0, 0, 0);
    run_pattern("R5 cart disabled", 16'h0001, 16'h6000, 16'h6000, 16'hFFFC);
    set_en(1, 0, 0);
    run_pattern("R5 cart enabled 0x6000", 16'h0001, 16'h6000, 16'h6000, 16'hFFFF);
    run_pattern("R5 cart enabled 0x7FFE", 16'h0001, 16'h7FFE, 16'h7FFE, 16'hFFFF);
    set_en(0, 0, 0);
    run_pattern("R6 low ram disabled", 16'h0001, 16'h2000, 16'h2000, 16'hFFFC);
    set_en(0, 1, 0);
    run_pattern("R6 low ram enabled", 16'h0001, 16'h3FFE, 16'h3FFE, 16'hFFFF);
    run_pattern("R7 high ram unaffected by low enable", 16'h0001, 16'hA000, 16'hA000, 16'hFFFC);
    set_en(0, 0, 1);
    run_pattern("R7 high ram enabled 0xA000", 16'h0001, 16'hA000, 16'hA000, 16'hFFFF);
    run_pattern("R7 high ram enabled 0xFFFE", 16'h0001, 16'hFFFE, 16'hFFFE, 16'hFFFF);
    run_pattern("R6 low ram unaffected by high enable", 16'h0001, 16'h2000, 16'h2000, 16'hFFFC);
    set_en(0, 0, 0);
  endtask

  task automatic t_addr_change;
    run_pattern("R8 address moves to fast page during wait", 16'h0001, 16'h4000, 16'h0000, 16'hFFFC);
    run_pattern("R8 address moves to slow page without strobe", 16'h0001, 16'h0000, 16'h4000, 16'hFFFF);
  endtask

  task automatic t_idle;
    run_pattern("R9 no strobe", 16'h0000, 16'h4000, 16'h4000, 16'hFFFF);
  endtask

  task automatic t_overlap;
    run_pattern("R10 second strobe at edge 1", 16'h0003, 16'h4000, 16'h4000, 16'hFF00);
    run_pattern("R10 second strobe at edge 3", 16'h0009, 16'h4000, 16'h4000, 16'hFF04);
    run_pattern("R10 second strobe at edge 5", 16'h0021, 16'h4000, 16'h4000, 16'hFF1C);
    run_pattern("R11 fast strobe while busy", 16'h0005, 16'h4000, 16'h8000, 16'hFFFC);
    run_pattern("R12 second strobe at edge 6", 16'h0041, 16'h4000, 16'h4000, 16'hFF3C);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_slow_basic();
    t_fixed_fast();
    t_optional();
    t_addr_change();
    t_idle();
    t_overlap();
    t_reset_mid_wait();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule